// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. It carries clause-22 read and write transactions to external PHYs. Software first stores the target PHY and register addresses in an address register. A store to the write-data register sends a write frame at once. A store that sets the read bit of the command register sends a read frame instead. A status register shows a busy flag, and a second flag stays set until fresh read data is available. The result of a read is returned in a read-data register.

The management clock is a divided copy of the system clock, and a configuration field picks the divide ratio. A management-reset bit in the same register aborts any frame and holds the engine idle. The data pin is handled through three separate signals: an output, an output enable and an input. A pad or tri-state buffer outside the block joins them.

The frame engine has four states. ST_IDLE moves to ST_SYNC on an accepted launch. ST_SYNC moves to ST_PRE on the next falling-clock tick. ST_PRE moves to ST_FRAME on the falling tick that ends the 32nd preamble bit. ST_FRAME returns to ST_IDLE on the falling tick that ends bit 63. While the management-reset bit is set, the engine goes to ST_IDLE from any state.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The registers sit at these word offsets: CFG=0, ADDR=1, CMD=2, WDATA=3, STATUS=4, RDATA=5. Reads of offsets 6 and 7 return 0. ADDR keeps the PHY address in bits [12:8] and the register address in bits [4:0], reads them back in the same positions, and supplies them to the next frame.
- R2: A store to WDATA while not busy sends a write frame, MSB first: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10 and the 16 stored data bits. Each bit changes only on a falling MDC edge, and the output enable is high for all 64 bits.
- R3: A store to CMD with bit 0 set while not busy sends a read frame: 32 ones, 01, opcode 10, PHY address and register address. The output enable drops for the turnaround and data bits (frame bits 46 to 63).
- R4: During a read the block samples mdio_i on each rising MDC edge of frame bits 48 to 63, MSB first. RDATA[15:0] holds those 16 bits once the frame ends.
- R5: STATUS bit 0 (busy) rises one cycle after an accepted launch, well within 30 cycles. It stays set until the falling MDC edge that ends bit 63.
- R6: STATUS bit 2 (read pending) is set with busy for read frames only. It clears in the same cycle that RDATA takes the new value.
- R7: A store to WDATA or CMD made while busy starts no frame, and the WDATA readback keeps its previous value.
- R8: Writing 1 to CFG bit 15 aborts any frame. From the next cycle, busy, read pending, MDC and the output enable are all low. No launch is accepted until the bit is cleared.
- R9: CFG[2:0] selects the MDC period in system clocks: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32, and 4 to 7 give 40. MDC is low for the first half of each period and high for the second half.
- R10: A CFG store that changes CFG[2:0] restarts the divider. MDC is low in the next cycle and rises after half of the new period.
- R11: After rst_n, every register reads 0, MDC and the output enable are low and the divider runs at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register store strobe |
| wr_addr | input | 3 | Register offset for the store |
| wr_data | input | 16 | Store data |
| rd_addr | input | 3 | Register offset for reads |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for serial data |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench aims at the edge where a frame ends. A design that clears busy one MDC edge early, or updates RDATA before sampling bit 63, drops the last data bit and clears the pending flag too soon. It also drives launches during busy and during a held reset. A design that does not gate these would restart a frame mid-stream or change the WDATA readback. It changes the clock select while MDC is running: without a divider restart the first period comes out short or long. It also checks the read turnaround, where a master that keeps the output enable high one bit too long would fight the PHY.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
    localparam int REG_AW    = 3;
    localparam int BUS_W     = 16;
    localparam int PHY_AW    = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_W;
    localparam int DATA_POS  = TA_POS + 2;
    localparam int SEL_W     = 3;
    localparam int DIV_SLOW  = 40;
    localparam int CNT_W     = $clog2(DIV_SLOW + 1);

    localparam logic [REG_AW-1:0] OFS_CFG    = 3'd0;
    localparam logic [REG_AW-1:0] OFS_ADDR   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CMD    = 3'd2;
    localparam logic [REG_AW-1:0] OFS_WDATA  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_STATUS = 3'd4;
    localparam logic [REG_AW-1:0] OFS_RDATA  = 3'd5;

    localparam int CFG_RST_BIT  = 15;
    localparam int ADDR_PHY_LSB = 8;
    localparam int ST_BUSY_BIT  = 0;
    localparam int ST_PEND_BIT  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PRE,
        ST_FRAME
    } mdio_state_t;

    function automatic int unsigned div_of(logic [SEL_W-1:0] sel);
        return (sel < 3'd4) ? (32'd4 << sel) : DIV_SLOW;
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             reload,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div_v;
    logic [CNT_W-1:0] half_v;

    assign div_v     = CNT_W'(div_of(sel));
    assign half_v    = div_v >> 1;
    assign rise_tick = !hold && (cnt == half_v - 1'b1);
    assign fall_tick = !hold && (cnt >= div_v - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (hold || reload) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_tick) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_tick) mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              busy,
    input  logic              rd_pend,
    input  logic [DATA_W-1:0] rdata,
    output logic              cfg_rst,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic [PHY_AW-1:0] phy_ad,
    output logic [REG_W-1:0]  reg_ad,
    output logic [DATA_W-1:0] wdata,
    output logic              wr_go,
    output logic              rd_go,
    output logic              sel_reload
);
    logic              cmd_q;
    logic [DATA_W-1:0] wdata_q;

    assign wr_go      = wr_en && (wr_addr == OFS_WDATA) && !busy && !cfg_rst;
    assign rd_go      = wr_en && (wr_addr == OFS_CMD) && wr_data[0] && !busy && !cfg_rst;
    assign sel_reload = wr_en && (wr_addr == OFS_CFG) && (wr_data[SEL_W-1:0] != cfg_sel);
    assign wdata      = wr_data[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rst <= 1'b0;
            cfg_sel <= '0;
            phy_ad  <= '0;
            reg_ad  <= '0;
            cmd_q   <= 1'b0;
            wdata_q <= '0;
        end else begin
            if (wr_en && wr_addr == OFS_CFG) begin
                cfg_rst <= wr_data[CFG_RST_BIT];
                cfg_sel <= wr_data[SEL_W-1:0];
            end
            if (wr_en && wr_addr == OFS_ADDR) begin
                phy_ad <= wr_data[ADDR_PHY_LSB +: PHY_AW];
                reg_ad <= wr_data[REG_W-1:0];
            end
            if (wr_en && wr_addr == OFS_CMD) cmd_q <= wr_data[0];
            if (wr_go) wdata_q <= wr_data[DATA_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_CFG: begin
                rd_data[CFG_RST_BIT] = cfg_rst;
                rd_data[SEL_W-1:0]   = cfg_sel;
            end
            OFS_ADDR: begin
                rd_data[ADDR_PHY_LSB +: PHY_AW] = phy_ad;
                rd_data[REG_W-1:0]              = reg_ad;
            end
            OFS_CMD:    rd_data[0] = cmd_q;
            OFS_WDATA:  rd_data[DATA_W-1:0] = wdata_q;
            OFS_STATUS: begin
                rd_data[ST_BUSY_BIT] = busy;
                rd_data[ST_PEND_BIT] = rd_pend;
            end
            OFS_RDATA:  rd_data[DATA_W-1:0] = rdata;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [PHY_AW-1:0] phy_ad,
    input  logic [REG_W-1:0]  reg_ad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_pend,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int CNT_BW = $clog2(FRAME_LEN);

    mdio_state_t          state_q, state_d;
    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_BW-1:0]    bitcnt;
    logic                 is_rd;
    logic [DATA_W-1:0]    cap;
    logic                 last_pre, last_bit, launch;
    logic [FRAME_LEN-1:0] frame_w, frame_r;

    assign last_pre = (bitcnt == CNT_BW'(PRE_LEN - 1));
    assign last_bit = (bitcnt == CNT_BW'(FRAME_LEN - 1));
    assign launch   = (state_q == ST_IDLE) && (wr_go || rd_go);
    assign frame_w  = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phy_ad, reg_ad, 2'b10, wdata};
    assign frame_r  = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phy_ad, reg_ad, {(2 + DATA_W){1'b1}}};

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (wr_go || rd_go)         state_d = ST_SYNC;
                ST_SYNC:  if (fall_tick)              state_d = ST_PRE;
                ST_PRE:   if (fall_tick && last_pre)  state_d = ST_FRAME;
                ST_FRAME: if (fall_tick && last_bit)  state_d = ST_IDLE;
                default:                              state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '1;
            bitcnt  <= '0;
            is_rd   <= 1'b0;
            cap     <= '0;
            rdata   <= '0;
            rd_pend <= 1'b0;
        end else if (hold) begin
            bitcnt  <= '0;
            rd_pend <= 1'b0;
        end else begin
            if (launch) begin
                shreg  <= rd_go ? frame_r : frame_w;
                is_rd  <= rd_go;
                bitcnt <= '0;
                if (rd_go) rd_pend <= 1'b1;
            end
            if (state_q == ST_SYNC && fall_tick) bitcnt <= '0;
            if ((state_q == ST_PRE || state_q == ST_FRAME) && fall_tick) begin
                shreg  <= {shreg[FRAME_LEN-2:0], 1'b1};
                bitcnt <= bitcnt + 1'b1;
            end
            if (state_q == ST_FRAME && rise_tick && is_rd && bitcnt >= CNT_BW'(DATA_POS))
                cap <= {cap[DATA_W-2:0], mdio_i};
            if (state_q == ST_FRAME && fall_tick && last_bit && is_rd) begin
                rdata   <= cap;
                rd_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = shreg[FRAME_LEN-1];
        mdio_oe = (state_q == ST_PRE) ||
                  ((state_q == ST_FRAME) && (!is_rd || bitcnt < CNT_BW'(TA_POS)));
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, rd_pend, cfg_rst, sel_reload;
    logic              wr_go, rd_go, rise_tick, fall_tick;
    logic [SEL_W-1:0]  cfg_sel;
    logic [PHY_AW-1:0] phy_ad;
    logic [REG_W-1:0]  reg_ad;
    logic [DATA_W-1:0] wdata, rdata;

    mdio_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .rd_pend(rd_pend),
        .rdata(rdata), .cfg_rst(cfg_rst), .cfg_sel(cfg_sel), .phy_ad(phy_ad),
        .reg_ad(reg_ad), .wdata(wdata), .wr_go(wr_go), .rd_go(rd_go),
        .sel_reload(sel_reload)
    );

    mdio_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .hold(cfg_rst), .reload(sel_reload), .sel(cfg_sel),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hold(cfg_rst), .rise_tick(rise_tick),
        .fall_tick(fall_tick), .wr_go(wr_go), .rd_go(rd_go), .phy_ad(phy_ad),
        .reg_ad(reg_ad), .wdata(wdata), .mdio_i(mdio_i), .busy(busy),
        .rd_pend(rd_pend), .rdata(rdata), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              busy,
    input logic              rd_pend,
    input logic              cfg_rst
);
    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy); // R5
    AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> busy); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |=> (!busy && !mdc && !mdio_oe && !rd_pend)); // R8
    AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_WDATA && !busy && !cfg_rst) |=> (busy && !rd_pend)); // R2
    AST_RD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_CMD && wr_data[0] && !busy && !cfg_rst) |=> (busy && rd_pend)); // R3
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_pend && wr_en && wr_addr == OFS_CMD && wr_data[0]) |=> !rd_pend); // R7
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy), .rd_pend(rd_pend), .cfg_rst(cfg_rst)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd4;
    logic [15:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [15:0] phy_val = 16'h0000;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int          m_divc, m_pos, t_dv, t_hf;
    logic        m_mdc, m_rd, m_nv, m_cfg_rst;
    logic [2:0]  m_sel;
    logic [4:0]  m_phy, m_reg;
    logic [63:0] m_vec;
    logic [15:0] m_cap, m_rdata;
    logic        t_rise, t_fall, t_idle, t_gw, t_gr, t_rel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_divc = 0; m_pos = -1; m_mdc = 0; m_rd = 0; m_nv = 0; m_cfg_rst = 0;
            m_sel = 0; m_phy = 0; m_reg = 0; m_vec = '1; m_cap = 0; m_rdata = 0;
        end else begin
            t_dv   = (m_sel < 4) ? (4 << m_sel) : 40;
            t_hf   = t_dv / 2;
            t_rise = !m_cfg_rst && (m_divc == t_hf - 1);
            t_fall = !m_cfg_rst && (m_divc == t_dv - 1);
            t_idle = (m_pos == -1);
            t_gw   = wr_en && wr_addr == 3 && t_idle && !m_cfg_rst;
            t_gr   = wr_en && wr_addr == 2 && wr_data[0] && t_idle && !m_cfg_rst;
            t_rel  = wr_en && wr_addr == 0 && wr_data[2:0] != m_sel;
            if (m_cfg_rst) begin
                m_pos = -1; m_nv = 0;
            end else if (t_gw || t_gr) begin
                m_vec = t_gr ? {32'hFFFF_FFFF, 2'b01, 2'b10, m_phy, m_reg, 18'h3FFFF}
                             : {32'hFFFF_FFFF, 2'b01, 2'b01, m_phy, m_reg, 2'b10, wr_data};
                m_pos = -2; m_rd = t_gr;
                if (t_gr) m_nv = 1;
            end else if (m_pos == -2) begin
                if (t_fall) m_pos = 0;
            end else if (m_pos >= 0) begin
                if (t_rise && m_rd && m_pos >= 48) m_cap = {m_cap[14:0], mdio_i};
                if (t_fall) begin
                    if (m_pos == 63) begin
                        m_pos = -1;
                        if (m_rd) begin m_rdata = m_cap; m_nv = 0; end
                    end else m_pos = m_pos + 1;
                end
            end
            if (m_cfg_rst || t_rel || t_fall) begin
                m_divc = 0; m_mdc = 0;
            end else begin
                m_divc = m_divc + 1;
                if (t_rise) m_mdc = 1;
            end
            if (wr_en && wr_addr == 0) begin m_cfg_rst = wr_data[15]; m_sel = wr_data[2:0]; end
            if (wr_en && wr_addr == 1) begin m_phy = wr_data[12:8]; m_reg = wr_data[4:0]; end
        end
    end

    // PHY stand-in: presents the read value MSB first during data bits
    always @(negedge clk)
        mdio_i <= (m_pos >= 48 && m_pos <= 63) ? phy_val[63 - m_pos] : 1'b1;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R9 mdc", {15'd0, mdc}, {15'd0, m_mdc});
            chk("R3 oe", {15'd0, mdio_oe},
                {15'd0, (m_pos >= 0) && (!m_rd || m_pos < 46)});
            if (m_pos >= 0 && mdio_oe)
                chk("R2 mdo", {15'd0, mdio_o}, {15'd0, m_vec[63 - m_pos]});
            if (rd_addr == 3'd4)
                chk("R5 status", rd_data, {13'd0, m_nv, 1'b0, m_pos != -1});
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
        rd_addr = 3'd4;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_pos != -1);
    endtask

    task automatic mdc_period(output int p);
        logic pv;
        int n;
        pv = mdc;
        @(negedge clk);
        while (!(mdc === 1'b1 && pv === 1'b0)) begin pv = mdc; @(negedge clk); end
        pv = mdc; n = 1;
        @(negedge clk);
        while (!(mdc === 1'b1 && pv === 1'b0)) begin pv = mdc; @(negedge clk); n++; end
        p = n;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int p, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        reg_read(3'd0, v); chk("R11 cfg", v, 16'h0000);
        reg_read(3'd1, v); chk("R11 addr", v, 16'h0000);
        reg_read(3'd4, v); chk("R11 status", v, 16'h0000);
        reg_read(3'd5, v); chk("R11 rdata", v, 16'h0000);
        chk("R11 mdc_oe", {14'd0, mdc, mdio_oe}, 16'h0000);
        mdc_period(p); chk("R11 period", 16'(p), 16'd4);

        // R1: address fields and unused offsets
        reg_write(3'd1, 16'h150A);
        reg_read(3'd1, v); chk("R1 addr", v, 16'h150A);
        reg_write(3'd1, 16'hFFFF);
        reg_read(3'd1, v); chk("R1 mask", v, 16'h1F1F);
        reg_read(3'd7, v); chk("R1 unmapped", v, 16'h0000);
        reg_write(3'd1, 16'h150A);

        // R2/R5/R7: write frame with stores while busy
        reg_write(3'd3, 16'hA5C3);
        reg_read(3'd4, v); chk("R5 busy", v, 16'h0001);
        repeat (40) @(negedge clk);
        reg_write(3'd2, 16'h0001);
        reg_write(3'd3, 16'h1234);
        reg_read(3'd4, v); chk("R7 no read", v, 16'h0001);
        wait_idle();
        reg_read(3'd4, v); chk("R5 done", v, 16'h0000);
        reg_read(3'd3, v); chk("R7 wdata kept", v, 16'hA5C3);
        reg_write(3'd2, 16'h0000);

        // R9: slow divider, then R3/R4/R6 read
        reg_write(3'd0, 16'h0004);
        mdc_period(p); chk("R9 div40", 16'(p), 16'd40);
        phy_val = 16'hBEEF;
        reg_write(3'd1, 16'h0311);
        reg_write(3'd2, 16'h0001);
        reg_read(3'd4, v); chk("R6 pend", v, 16'h0005);
        wait_idle();
        reg_read(3'd4, v); chk("R6 clear", v, 16'h0000);
        reg_read(3'd5, v); chk("R4 rdata", v, 16'hBEEF);
        reg_write(3'd2, 16'h0000);

        // R9: other encodings
        reg_write(3'd0, 16'h0001); mdc_period(p); chk("R9 div8", 16'(p), 16'd8);
        reg_write(3'd0, 16'h0002); mdc_period(p); chk("R9 div16", 16'(p), 16'd16);
        reg_write(3'd0, 16'h0003); mdc_period(p); chk("R9 div32", 16'(p), 16'd32);
        reg_write(3'd0, 16'h0007); mdc_period(p); chk("R9 div40b", 16'(p), 16'd40);

        // R10: select change restarts divider mid-period
        reg_write(3'd0, 16'h0000);
        repeat (5) @(negedge clk);
        reg_write(3'd0, 16'h0001);
        chk("R10 mdc low", {15'd0, mdc}, 16'h0000);
        n = 0;
        while (mdc !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        chk("R10 first rise", 16'(n), 16'd4);

        // R4: second read at div 8 with a different pattern
        phy_val = 16'h8001;
        reg_write(3'd2, 16'h0001);
        wait_idle();
        reg_read(3'd5, v); chk("R4 rdata2", v, 16'h8001);
        reg_write(3'd2, 16'h0000);

        // R8: management reset aborts and blocks launches
        reg_write(3'd3, 16'h0F0F);
        repeat (60) @(negedge clk);
        reg_write(3'd0, 16'h8001);
        @(negedge clk);
        chk("R8 quiet", {13'd0, mdc, mdio_oe, dut_i.rd_data[0]}, 16'h0000);
        reg_write(3'd3, 16'h3333);
        reg_write(3'd2, 16'h0001);
        repeat (20) @(negedge clk);
        reg_read(3'd4, v); chk("R8 held", v, 16'h0000);
        chk("R8 mdc held", {15'd0, mdc}, 16'h0000);
        reg_write(3'd2, 16'h0000);
        reg_write(3'd0, 16'h0000);
        reg_write(3'd3, 16'h5A5A);
        reg_read(3'd4, v); chk("R8 relaunch", v, 16'h0001);
        wait_idle();
        reg_read(3'd3, v); chk("R8 wdata", v, 16'h5A5A);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule